// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block carries one or more logic levels across a modelled isolation barrier using two one-cycle pulse wires per channel. On the sending side an encoder watches each data input. A rising level becomes a pulse on that channel's set wire, and a falling level becomes a pulse on its clear wire. When the input stays quiet, the encoder repeats a pulse that matches the present level at a fixed spacing. This keeps the far side correct at DC even if a pulse is lost.

On the receiving side a decoder holds a bistable level per channel. A lone set pulse drives the level high and a lone clear pulse drives it low. A watchdog measures the time since the last valid pulse. When that time runs past its limit, the decoder assumes the sender has lost power and presents a safe default level chosen per channel. For example, a received-data line can default high and a driver-enable line can default low, so the line driver it feeds goes to high impedance. Each side has its own power-good input.

The barrier wires leave the block on one set of ports and come back in on another. The integrator (or a bench) loops them together and can disturb them in between.

Top module: `iso_pulse_link`

## Requirements
- R1: On a channel with the sender powered, a rising `din` bit sampled at clock edge k gives `bar_set_o` high for the cycle after edge k, and a falling bit gives `bar_rst_o`. The set and clear outputs of one channel are never high together.
- R2: Every pulse on `bar_set_o` or `bar_rst_o` lasts exactly one clock cycle.
- R3: While `din` of a channel stays constant, the encoder sends a pulse of the current level (set for 1, clear for 0) every REFRESH_CYC cycles, counted from the previous pulse of that channel.
- R4: If an input change arrives in the same cycle a refresh is due, the change pulse is sent instead of the refresh. The next refresh then follows REFRESH_CYC cycles after that change pulse.
- R5: With the receiver powered, a set pulse alone on `bar_set_i` makes `dout` 1 from the next cycle, and a clear pulse alone on `bar_rst_i` makes it 0. Through a direct loopback, a change on `din` reaches `dout` two cycles after it is sampled.
- R6: If no valid pulse is captured for WATCHDOG_CYC cycles after the last one, `link_lost` rises and `dout` takes DEFAULT_LVL. With the default parameters, bit 0 falls back to 1 and bit 1 falls back to 0.
- R7: After a timeout, the first valid pulse sets `dout` to the pulse's level and clears `link_lost` in the next cycle.
- R8: A set and a clear pulse on the same channel in the same cycle leave `dout` unchanged and raise `collide_err` for that channel for one cycle.
- R9: While `tx_pwr_ok` is low no pulses are sent. On the first clock edge with it high again, each channel sends a pulse of its current `din` level.
- R10: While `rx_pwr_ok` is low, `dout` equals DEFAULT_LVL and `link_lost` is all ones from the next cycle, and incoming pulses are ignored. After power returns, the default stays until a valid pulse arrives.
- R11: During reset `dout` equals DEFAULT_LVL, `link_lost` is all ones, and no pulse or collision flag is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides of the model |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_pwr_ok | input | 1 | Sending side power good |
| rx_pwr_ok | input | 1 | Receiving side power good |
| din | input | NUM_CH | Levels to carry, one bit per channel |
| bar_set_o | output | NUM_CH | Set pulses leaving the encoder |
| bar_rst_o | output | NUM_CH | Clear pulses leaving the encoder |
| bar_set_i | input | NUM_CH | Set pulses arriving at the decoder |
| bar_rst_i | input | NUM_CH | Clear pulses arriving at the decoder |
| dout | output | NUM_CH | Decoded levels, or the default levels when the link is down |
| link_lost | output | NUM_CH | Channel is presenting its default level |
| collide_err | output | NUM_CH | One-cycle flag for a set and clear arriving together |

## Verification
The decoder checks assume that the arriving wires carry single-cycle pulses. A simultaneous set and clear is allowed only as a deliberate fault. The bench meets this by feeding the encoder outputs straight back, and it adds its own pulses only for one cycle at moments chosen clear of the encoder's refresh slots. The encoder checks assume `din` is stable around the sampling edge. The bench drives every input on the falling clock edge. It also places power changes right after a known pulse, so the watchdog and refresh counts it predicts start from a known point.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  // One channel's pair of barrier wires.
  typedef struct packed {
    logic set;
    logic rst;
  } barrier_pulse_t;

  localparam barrier_pulse_t PULSE_NONE = '{set: 1'b0, rst: 1'b0};

  // Pulse that conveys a given level.
  function automatic barrier_pulse_t level_pulse(input logic lvl);
    level_pulse.set = lvl;
    level_pulse.rst = ~lvl;
  endfunction

endpackage

// File: rtl/iso_reset_sync.sv
module iso_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/iso_refresh_timer.sv
module iso_refresh_timer #(
  parameter int REFRESH_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,      // sender powered
  input  logic restart,  // an edge pulse is being sent
  output logic due       // refresh slot this cycle
);

  localparam int CW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign due = run && (cnt_q == LAST);

  always_comb begin
    if (!run)                cnt_d = LAST;   // first powered edge is a slot
    else if (restart || due) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder
  import iso_link_pkg::*;
#(
  parameter int REFRESH_CYC = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_ok,
  input  logic           din,
  output barrier_pulse_t pulse_o
);

  logic           din_q;
  logic           edge_seen;
  logic           refresh_due;
  barrier_pulse_t pulse_q, pulse_d;

  assign edge_seen = pwr_ok && (din != din_q);

  iso_refresh_timer #(.REFRESH_CYC(REFRESH_CYC)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (pwr_ok),
    .restart (edge_seen),
    .due     (refresh_due)
  );

  // Edge beats refresh; nothing leaves an unpowered sender.
  always_comb begin
    pulse_d = PULSE_NONE;
    if (pwr_ok) begin
      if (edge_seen)        pulse_d = level_pulse(din);
      else if (refresh_due) pulse_d = level_pulse(din_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= 1'b0;
      pulse_q <= PULSE_NONE;
    end else begin
      din_q   <= din;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/iso_pulse_decoder.sv
module iso_pulse_decoder
  import iso_link_pkg::*;
#(
  parameter int   WATCHDOG_CYC = 500,
  parameter logic DEFAULT_LVL  = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_ok,
  input  barrier_pulse_t pulse_i,
  output logic           dout,
  output logic           lost,
  output logic           collide
);

  localparam int WW = (WATCHDOG_CYC > 2) ? $clog2(WATCHDOG_CYC) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(WATCHDOG_CYC - 1);

  logic          lvl_q, lvl_d;
  logic          lost_q, lost_d;
  logic          err_q, err_d;
  logic [WW-1:0] wd_q, wd_d;
  logic          valid;

  assign valid = pulse_i.set ^ pulse_i.rst;

  always_comb begin
    lvl_d  = lvl_q;
    lost_d = lost_q;
    wd_d   = wd_q;
    err_d  = 1'b0;
    if (!pwr_ok) begin
      lvl_d  = DEFAULT_LVL;
      lost_d = 1'b1;
      wd_d   = '0;
    end else if (valid) begin
      lvl_d  = pulse_i.set;
      lost_d = 1'b0;
      wd_d   = '0;
    end else begin
      err_d = pulse_i.set & pulse_i.rst;
      if (wd_q == WD_LAST) lost_d = 1'b1;
      else                 wd_d   = wd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= DEFAULT_LVL;
      lost_q <= 1'b1;
      err_q  <= 1'b0;
      wd_q   <= '0;
    end else begin
      lvl_q  <= lvl_d;
      lost_q <= lost_d;
      err_q  <= err_d;
      wd_q   <= wd_d;
    end
  end

  assign dout    = lost_q ? DEFAULT_LVL : lvl_q;
  assign lost    = lost_q;
  assign collide = err_q;

endmodule

// File: rtl/iso_pulse_link.sv
module iso_pulse_link
  import iso_link_pkg::*;
#(
  parameter int                NUM_CH       = 2,
  parameter int                REFRESH_CYC  = 100,
  parameter int                WATCHDOG_CYC = 500,
  parameter logic [NUM_CH-1:0] DEFAULT_LVL  = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_pwr_ok,
  input  logic              rx_pwr_ok,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] bar_set_o,
  output logic [NUM_CH-1:0] bar_rst_o,
  input  logic [NUM_CH-1:0] bar_set_i,
  input  logic [NUM_CH-1:0] bar_rst_i,
  output logic [NUM_CH-1:0] dout,
  output logic [NUM_CH-1:0] link_lost,
  output logic [NUM_CH-1:0] collide_err
);

  if (REFRESH_CYC < 2) begin : g_bad_refresh
    $error("REFRESH_CYC must be at least 2");
  end
  if (WATCHDOG_CYC <= 2 * REFRESH_CYC) begin : g_bad_watchdog
    $error("WATCHDOG_CYC must exceed twice REFRESH_CYC");
  end

  logic rst_sync_n;

  iso_reset_sync rsync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    barrier_pulse_t tx_pulse;
    barrier_pulse_t rx_pulse;

    iso_edge_encoder #(.REFRESH_CYC(REFRESH_CYC)) enc_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pwr_ok  (tx_pwr_ok),
      .din     (din[c]),
      .pulse_o (tx_pulse)
    );

    assign bar_set_o[c] = tx_pulse.set;
    assign bar_rst_o[c] = tx_pulse.rst;
    assign rx_pulse     = '{set: bar_set_i[c], rst: bar_rst_i[c]};

    iso_pulse_decoder #(
      .WATCHDOG_CYC (WATCHDOG_CYC),
      .DEFAULT_LVL  (DEFAULT_LVL[c])
    ) dec_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pwr_ok  (rx_pwr_ok),
      .pulse_i (rx_pulse),
      .dout    (dout[c]),
      .lost    (link_lost[c]),
      .collide (collide_err[c])
    );
  end

endmodule

// File: rtl/iso_pulse_link_chk.sv
module iso_pulse_link_chk #(
  parameter int                NUM_CH      = 2,
  parameter logic [NUM_CH-1:0] DEFAULT_LVL = 2'b01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_pwr_ok,
  input logic              rx_pwr_ok,
  input logic [NUM_CH-1:0] din,
  input logic [NUM_CH-1:0] bar_set_o,
  input logic [NUM_CH-1:0] bar_rst_o,
  input logic [NUM_CH-1:0] bar_set_i,
  input logic [NUM_CH-1:0] bar_rst_i,
  input logic [NUM_CH-1:0] dout,
  input logic [NUM_CH-1:0] link_lost,
  input logic [NUM_CH-1:0] collide_err
);

  // R9: unpowered sender stays silent
  a_r9_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pwr_ok |=> (bar_set_o == '0) && (bar_rst_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R1: rising input yields a set pulse
    a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pwr_ok && $rose(din[c]) |=> bar_set_o[c] && !bar_rst_o[c]);

    // R1: falling input yields a clear pulse
    a_r1_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pwr_ok && $fell(din[c]) |=> bar_rst_o[c] && !bar_set_o[c]);

    // R1: never both wires at once from the encoder
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bar_set_o[c] && bar_rst_o[c]));

    // R2: pulses are a single cycle wide
    a_r2_set_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      bar_set_o[c] |=> !bar_set_o[c]);
    a_r2_rst_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      bar_rst_o[c] |=> !bar_rst_o[c]);

    // R5: a lone set pulse drives the output high
    a_r5_set_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pwr_ok && bar_set_i[c] && !bar_rst_i[c] |=> dout[c] && !link_lost[c]);

    // R5: a lone clear pulse drives the output low
    a_r5_rst_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pwr_ok && bar_rst_i[c] && !bar_set_i[c] |=> !dout[c] && !link_lost[c]);

    // R8: a collision holds the output and flags it
    a_r8_collide_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pwr_ok && bar_set_i[c] && bar_rst_i[c] |=> collide_err[c] && $stable(dout[c]));

    // R10: an unpowered receiver shows its default
    a_r10_rx_default: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_pwr_ok |=> (dout[c] == DEFAULT_LVL[c]) && link_lost[c]);
  end

endmodule

bind iso_pulse_link iso_pulse_link_chk #(
  .NUM_CH      (NUM_CH),
  .DEFAULT_LVL (DEFAULT_LVL)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tx_pwr_ok   (tx_pwr_ok),
  .rx_pwr_ok   (rx_pwr_ok),
  .din         (din),
  .bar_set_o   (bar_set_o),
  .bar_rst_o   (bar_rst_o),
  .bar_set_i   (bar_set_i),
  .bar_rst_i   (bar_rst_i),
  .dout        (dout),
  .link_lost   (link_lost),
  .collide_err (collide_err)
);

// File: tb/iso_pulse_link_tb_top.sv
module iso_pulse_link_tb_top;

  localparam int          NCH = 2;
  localparam int          R   = 16;
  localparam int          W   = 40;
  localparam logic [1:0]  DEF = 2'b01;

  logic           clk;
  logic           rst_n;
  logic           tx_pwr_ok;
  logic           rx_pwr_ok;
  logic [NCH-1:0] din;
  logic [NCH-1:0] bar_set_o, bar_rst_o;
  logic [NCH-1:0] bar_set_i, bar_rst_i;
  logic [NCH-1:0] inj_set, inj_rst;
  logic [NCH-1:0] dout, link_lost, collide_err;

  int n_tests = 0;
  int n_fail  = 0;

  assign bar_set_i = bar_set_o | inj_set;
  assign bar_rst_i = bar_rst_o | inj_rst;

  iso_pulse_link #(
    .NUM_CH       (NCH),
    .REFRESH_CYC  (R),
    .WATCHDOG_CYC (W),
    .DEFAULT_LVL  (DEF)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_pwr_ok   (tx_pwr_ok),
    .rx_pwr_ok   (rx_pwr_ok),
    .din         (din),
    .bar_set_o   (bar_set_o),
    .bar_rst_o   (bar_rst_o),
    .bar_set_i   (bar_set_i),
    .bar_rst_i   (bar_rst_i),
    .dout        (dout),
    .link_lost   (link_lost),
    .collide_err (collide_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance until a pulse leaves the encoder on channel ch.
  task automatic wait_pulse(input int ch, input int limit, output int cyc, output logic was_set);
    cyc = 0;
    was_set = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      cyc++;
      if (bar_set_o[ch] || bar_rst_o[ch]) begin
        was_set = bar_set_o[ch];
        break;
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tx_pwr_ok = 1'b1; rx_pwr_ok = 1'b1;
    din = '0; inj_set = '0; inj_rst = '0;
    repeat (4) @(negedge clk);
    chk("R11 dout", dout, DEF);
    chk("R11 link_lost", link_lost, 2'b11);
    chk("R11 pulses", {bar_set_o, bar_rst_o}, 4'b0);
    chk("R11 collide", collide_err, 2'b00);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 dout after power-up", dout, 2'b00);
  endtask

  task automatic t_edge_latency;
    din[0] = 1'b1;
    @(negedge clk);
    chk("R1 set pulse", {bar_set_o[0], bar_rst_o[0]}, 2'b10);
    chk("R5 not yet", dout[0], 1'b0);
    @(negedge clk);
    chk("R2 set width", bar_set_o[0], 1'b0);
    chk("R5 rise latency", dout[0], 1'b1);
    repeat (3) @(negedge clk);
    din[0] = 1'b0;
    @(negedge clk);
    chk("R1 clear pulse", {bar_set_o[0], bar_rst_o[0]}, 2'b01);
    @(negedge clk);
    chk("R2 clear width", bar_rst_o[0], 1'b0);
    chk("R5 fall latency", dout[0], 1'b0);
  endtask

  task automatic t_refresh;
    int   cyc;
    logic s;
    din[1] = 1'b1;
    @(negedge clk);
    chk("R1 ch1 set", bar_set_o[1], 1'b1);
    for (int k = 0; k < 3; k++) begin
      wait_pulse(1, R + 5, cyc, s);
      chk("R3 refresh spacing", cyc, R);
      chk("R3 refresh level", s, 1'b1);
    end
    chk("R3 link kept", link_lost, 2'b00);
  endtask

  task automatic t_priority;
    int   cyc;
    logic s;
    wait_pulse(1, R + 5, cyc, s);
    repeat (R - 1) @(negedge clk);
    din[1] = 1'b0;          // sampled on the edge where a refresh is due
    @(negedge clk);
    chk("R4 edge wins", {bar_set_o[1], bar_rst_o[1]}, 2'b01);
    wait_pulse(1, R + 5, cyc, s);
    chk("R4 timer restart", cyc, R);
    chk("R4 refresh level", s, 1'b0);
  endtask

  task automatic t_timeout;
    int q0, q1;
    din = 2'b11;
    repeat (3) @(negedge clk);
    din = 2'b10;            // ch0 falls, ch1 stays: force a ch0 pulse
    @(negedge clk);
    din = 2'b01;            // both change: aligned pulses next cycle
    @(negedge clk);
    din = 2'b10;
    @(negedge clk);         // pulses of both channels visible now
    tx_pwr_ok = 1'b0;
    q0 = 0; q1 = 0;
    for (int k = 0; k < W + 1; k++) begin
      @(negedge clk);
      chk("R9 quiet", {bar_set_o, bar_rst_o}, 4'b0);
      q0++; q1++;
      if (k == W - 1) begin
        chk("R6 before limit", link_lost, 2'b00);
        chk("R6 level held", dout, 2'b10);
      end
    end
    chk("R6 timed out", link_lost, 2'b11);
    chk("R6 default", dout, DEF);
  endtask

  task automatic t_first_pulse;
    inj_set[1] = 1'b1;
    @(negedge clk);
    inj_set[1] = 1'b0;
    chk("R7 set after timeout", dout[1], 1'b1);
    chk("R7 lost cleared", link_lost[1], 1'b0);
    inj_rst[0] = 1'b1;
    @(negedge clk);
    inj_rst[0] = 1'b0;
    chk("R7 clear after timeout", dout[0], 1'b0);
    chk("R7 lost cleared ch0", link_lost[0], 1'b0);
  endtask

  task automatic t_recover;
    tx_pwr_ok = 1'b1;
    @(negedge clk);
    chk("R9 power-up set", bar_set_o, 2'b10);
    chk("R9 power-up clear", bar_rst_o, 2'b01);
    @(negedge clk);
    chk("R9 recovered", dout, 2'b10);
    chk("R9 link up", link_lost, 2'b00);
  endtask

  task automatic t_collide;
    inj_set[0] = 1'b1; inj_rst[0] = 1'b1;
    @(negedge clk);
    inj_set[0] = 1'b0; inj_rst[0] = 1'b0;
    chk("R8 flag", collide_err, 2'b01);
    chk("R8 held", dout, 2'b10);
    @(negedge clk);
    chk("R8 one cycle", collide_err, 2'b00);
  endtask

  task automatic t_rx_power;
    din = 2'b01;
    @(negedge clk);
    din = 2'b10;
    @(negedge clk);         // aligned pulses visible (cycle n)
    @(negedge clk);         // n+1
    chk("R5 aligned", dout, 2'b10);
    rx_pwr_ok = 1'b0;
    @(negedge clk);         // n+2
    chk("R10 default", dout, DEF);
    chk("R10 lost", link_lost, 2'b11);
    inj_set[1] = 1'b1;
    @(negedge clk);         // n+3
    inj_set[1] = 1'b0;
    @(negedge clk);         // n+4
    chk("R10 pulse ignored", dout[1], 1'b0);
    repeat (R - 3) @(negedge clk);   // n+R+1, refresh at n+R already passed
    rx_pwr_ok = 1'b1;
    @(negedge clk);         // n+R+2
    chk("R10 still default", dout, DEF);
    chk("R10 still lost", link_lost, 2'b11);
    repeat (R - 2) @(negedge clk);   // n+2R, refresh visible
    chk("R3 aligned refresh", bar_set_o, 2'b10);
    @(negedge clk);
    chk("R10 restored", dout, 2'b10);
    chk("R10 link up", link_lost, 2'b00);
  endtask

  initial begin
    t_reset();
    t_edge_latency();
    t_refresh();
    t_priority();
    t_timeout();
    t_first_pulse();
    t_recover();
    t_collide();
    t_rx_power();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule